// File: doc/BRIEF.md
# Serial Flash Instruction Front End

This block is the slave side of a serial paged flash. It receives SPI traffic in clock mode 0 or mode 3. It assembles the opcode and the 24-bit address, and it decides whether each command is executed. It keeps the write-enable latch and the deep power-down state. It streams read data and the status byte back on the data-out line. Commands that change the array go to a separate array sequencer as a single-cycle request. The sequencer answers with a busy level, and that level is reported as write-in-progress.

All serial pins are sampled by the system clock through a synchroniser, so the serial clock must be several times slower than `clk_i`. For page write and page program the data bytes are streamed to the sequencer as they arrive. The sequencer stages them and commits them only when a request follows at the end of the same select. Array read data comes back on `rd_data_i`, combinationally or within one cycle of `rd_addr_o` changing.

Top module: `sflash_cmd_front`

## Requirements
- R1: After reset, `miso_oe_o`, `req_o` and `wr_valid_o` are low and the status byte reads 00h.
- R2: Bits are taken on rising serial-clock edges, MSB first, and data out changes only after falling edges. This holds with the clock idling low (mode 0) and idling high (mode 3).
- R3: Opcode 05h streams the status byte {6'b0, latch, busy}: latch in bit 1, busy in bit 0. The byte is sampled again at every byte boundary for as long as select stays low.
- R4: Opcode 03h followed by three address bytes streams array bytes from that address, MSB first. The address increments once per byte.
- R5: Opcode 0Bh behaves as 03h, with one dummy byte inserted between the address and the first data bit.
- R6: 06h sets the write-enable latch and 04h clears it. Either takes effect only if select rises after a non-zero multiple of eight clocks.
- R7: Requests carry `op_o` as 0 for page write (0Ah), 1 for page program (02h), 2 for page erase (DBh) and 3 for sector erase (D8h), along with the address on `addr_o`. A request is issued for one cycle when select rises on a byte boundary after the full address, plus at least one data byte for 0Ah and 02h.
- R8: With the write-enable latch clear, none of 0Ah, 02h, DBh or D8h issues a request.
- R9: The write-enable latch clears when `busy_i` falls.
- R10: While `busy_i` is high, read, fast read and all modifying commands are ignored: there is no request and no data output. Status reads still work.
- R11: B9h enters deep power-down. In that state every opcode except ABh is ignored, and ABh on a byte boundary leaves the state.
- R12: `miso_oe_o` is low while select is high. A select that is already low when reset is released is ignored until select goes high and then low again.
- R13: Each data byte of an enabled page write or page program appears once on `wr_data_o` with a one-cycle `wr_valid_o`, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for data out (low means high impedance) |
| busy_i | input | 1 | Array sequencer busy, shown as write-in-progress |
| req_o | output | 1 | One-cycle request to the array sequencer |
| op_o | output | 2 | Requested array operation |
| addr_o | output | 24 | Address of the current command |
| wr_valid_o | output | 1 | Data byte strobe for page write and program |
| wr_data_o | output | 8 | Data byte for page write and program |
| rd_addr_o | output | 24 | Array read address |
| rd_data_i | input | 8 | Array read data |

## Verification
The bench targets several corner cases, each chosen to expose a specific fault:

- **Select boundaries.** It ends selects a few bits short of or past a byte boundary, and it sends a page write with no data byte. A decoder that accepts on any select rise would issue requests or set the latch in these cases.
- **Status refresh.** It holds one status read open across the end of a busy period. A design that latches status only once would keep reporting busy.
- **Pins low at reset.** It keeps select low through reset and clocks in a write enable. A design that does not wait for a fresh select edge would set the latch.
- **Busy and power-down.** It checks that the output never turns on during a read issued while busy, nor in deep power-down. It also checks that a write enable sent while busy is wiped when busy falls.

// File: rtl/spi_flash_pkg.sv
package spi_flash_pkg;
  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_WRDI  = 8'h04;
  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_FREAD = 8'h0B;
  localparam logic [7:0] OPC_PW    = 8'h0A;
  localparam logic [7:0] OPC_PP    = 8'h02;
  localparam logic [7:0] OPC_PE    = 8'hDB;
  localparam logic [7:0] OPC_SE    = 8'hD8;
  localparam logic [7:0] OPC_DP    = 8'hB9;
  localparam logic [7:0] OPC_RDP   = 8'hAB;

  typedef enum logic [1:0] {
    AOP_PWRITE = 2'd0,
    AOP_PPROG  = 2'd1,
    AOP_PERASE = 2'd2,
    AOP_SERASE = 2'd3
  } arr_op_e;

  typedef enum logic [2:0] {
    PH_OPC, PH_ADDR, PH_DUMMY, PH_WDATA, PH_RDATA, PH_STAT, PH_TAIL, PH_SKIP
  } phase_e;
endpackage

// File: rtl/spi_flash_sync.sv
module spi_flash_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  input  logic mosi_i,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic mosi_o
);
  logic [STAGES-1:0] cs_sr, ck_sr, di_sr;
  logic cs_d, ck_d;

  // cs resets as "low" so a select held low through reset gives no fall edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_sr <= '0;
      ck_sr <= '0;
      di_sr <= '0;
      cs_d  <= 1'b0;
      ck_d  <= 1'b0;
    end else begin
      cs_sr <= {cs_sr[STAGES-2:0], cs_ni};
      ck_sr <= {ck_sr[STAGES-2:0], sclk_i};
      di_sr <= {di_sr[STAGES-2:0], mosi_i};
      cs_d  <= cs_sr[STAGES-1];
      ck_d  <= ck_sr[STAGES-1];
    end
  end

  assign cs_fall_o   = cs_d & ~cs_sr[STAGES-1];
  assign cs_rise_o   = ~cs_d & cs_sr[STAGES-1];
  assign sclk_rise_o = ~ck_d & ck_sr[STAGES-1];
  assign sclk_fall_o = ck_d & ~ck_sr[STAGES-1];
  assign mosi_o      = di_sr[STAGES-1];
endmodule

// File: rtl/spi_flash_rx.sv
module spi_flash_rx #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             end_i,
  input  logic             rise_i,
  input  logic             mosi_i,
  output logic             active_o,
  output logic [CNT_W-1:0] bit_cnt_o,
  output logic [7:0]       byte_o,
  output logic             done_o
);
  logic             active_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic [6:0]       sh_q;
  logic [7:0]       byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      byte_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else if (end_i) begin
        active_q <= 1'b0;
      end else if (active_q && rise_i && cnt_q != '1) begin
        cnt_q <= cnt_q + 1'b1;
        sh_q  <= {sh_q[5:0], mosi_i};
        if (cnt_q[2:0] == 3'd7) begin
          byte_q <= {sh_q, mosi_i};
          done_q <= 1'b1;
        end
      end
    end
  end

  assign active_o  = active_q;
  assign bit_cnt_o = cnt_q;
  assign byte_o    = byte_q;
  assign done_o    = done_q;

  AST_DONE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> cnt_q[2:0] == 3'd0) else $error("byte strobe off boundary"); // R2
endmodule

// File: rtl/spi_flash_ctrl.sv
module spi_flash_ctrl
  import spi_flash_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              end_i,
  input  logic              fall_i,
  input  logic              active_i,
  input  logic [CNT_W-1:0]  bit_cnt_i,
  input  logic [7:0]        byte_i,
  input  logic              done_i,
  input  logic              busy_i,
  input  logic [7:0]        rd_data_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              req_o,
  output logic [1:0]        op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_valid_o,
  output logic [7:0]        wr_data_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  localparam int IDX_W = CNT_W - 3;
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam logic [IDX_W-1:0] IDX_ADDR_END = IDX_W'(ADDR_BYTES + 1);

  phase_e            phase_q;
  arr_op_e           op_q;
  logic [7:0]        opc_q, tx_q, wr_data_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wel_q, dp_q, got_data_q, out_on_q, req_q, wr_valid_q, busy_q;
  logic [IDX_W-1:0]  idx;
  logic              on_bound, out_phase, busy_fall;

  assign idx       = bit_cnt_i[CNT_W-1:3];
  assign on_bound  = bit_cnt_i[2:0] == 3'd0 && bit_cnt_i != '0;
  assign out_phase = phase_q == PH_RDATA || phase_q == PH_STAT;
  assign busy_fall = busy_q & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_SKIP;
      op_q       <= AOP_PWRITE;
      opc_q      <= '0;
      tx_q       <= '0;
      wr_data_q  <= '0;
      addr_q     <= '0;
      wel_q      <= 1'b0;
      dp_q       <= 1'b0;
      got_data_q <= 1'b0;
      out_on_q   <= 1'b0;
      req_q      <= 1'b0;
      wr_valid_q <= 1'b0;
      busy_q     <= 1'b0;
    end else begin
      req_q      <= 1'b0;
      wr_valid_q <= 1'b0;
      busy_q     <= busy_i;

      if (start_i) begin
        phase_q    <= PH_OPC;
        got_data_q <= 1'b0;
        out_on_q   <= 1'b0;
      end else if (active_i && done_i) begin
        unique case (phase_q)
          PH_OPC: begin
            opc_q <= byte_i;
            if (dp_q && byte_i != OPC_RDP) phase_q <= PH_SKIP;
            else begin
              case (byte_i)
                OPC_RDSR: phase_q <= PH_STAT;
                OPC_READ, OPC_FREAD, OPC_PW, OPC_PP, OPC_PE, OPC_SE:
                  phase_q <= busy_i ? PH_SKIP : PH_ADDR;
                OPC_WREN, OPC_WRDI, OPC_RDP: phase_q <= PH_TAIL;
                OPC_DP: phase_q <= busy_i ? PH_SKIP : PH_TAIL;
                default: phase_q <= PH_SKIP;
              endcase
            end
          end
          PH_ADDR: begin
            addr_q <= {addr_q[ADDR_W-9:0], byte_i};
            if (idx == IDX_ADDR_END) begin
              case (opc_q)
                OPC_READ:       phase_q <= PH_RDATA;
                OPC_FREAD:      phase_q <= PH_DUMMY;
                OPC_PW, OPC_PP: phase_q <= PH_WDATA;
                default:        phase_q <= PH_TAIL;
              endcase
            end
          end
          PH_DUMMY: phase_q <= PH_RDATA;
          PH_WDATA: begin
            got_data_q <= 1'b1;
            wr_valid_q <= wel_q;
            wr_data_q  <= byte_i;
          end
          default: ;
        endcase
      end

      if (active_i && fall_i && out_phase) begin
        if (on_bound) begin
          out_on_q <= 1'b1;
          if (phase_q == PH_STAT) tx_q <= {6'b0, wel_q, busy_i};
          else begin
            tx_q   <= rd_data_i;
            addr_q <= addr_q + 1'b1;
          end
        end else begin
          tx_q <= {tx_q[6:0], 1'b0};
        end
      end

      // acceptance at select release
      if (active_i && end_i && on_bound) begin
        if (phase_q == PH_TAIL) begin
          case (opc_q)
            OPC_WREN: wel_q <= 1'b1;
            OPC_WRDI: wel_q <= 1'b0;
            OPC_DP:   dp_q  <= 1'b1;
            OPC_RDP:  dp_q  <= 1'b0;
            OPC_PE, OPC_SE: if (wel_q && !busy_i) begin
              req_q <= 1'b1;
              op_q  <= (opc_q == OPC_PE) ? AOP_PERASE : AOP_SERASE;
            end
            default: ;
          endcase
        end else if (phase_q == PH_WDATA && got_data_q && wel_q && !busy_i) begin
          req_q <= 1'b1;
          op_q  <= (opc_q == OPC_PW) ? AOP_PWRITE : AOP_PPROG;
        end
      end

      if (busy_fall) wel_q <= 1'b0;
    end
  end

  assign miso_o     = tx_q[7];
  assign miso_oe_o  = active_i && out_on_q && out_phase;
  assign req_o      = req_q;
  assign op_o       = op_q;
  assign addr_o     = addr_q;
  assign rd_addr_o  = addr_q;
  assign wr_valid_o = wr_valid_q;
  assign wr_data_o  = wr_data_q;

  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o) else $error("request longer than one cycle"); // R7
  AST_WEL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |=> !wel_q) else $error("latch survived cycle end"); // R9
  AST_DP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dp_q |-> !miso_oe_o && !req_o) else $error("activity in power-down"); // R11
  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(active_i && fall_i) |=> $stable(tx_q)) else $error("output moved off a fall edge"); // R2
  AST_OE_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> !miso_oe_o) else $error("output enabled while deselected"); // R12
endmodule

// File: rtl/sflash_cmd_front.sv
module sflash_cmd_front
  import spi_flash_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic              busy_i,
  output logic              req_o,
  output logic [1:0]        op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_valid_o,
  output logic [7:0]        wr_data_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i
);
  logic cs_fall, cs_rise, ck_rise, ck_fall, di;
  logic active, done;
  logic [CNT_W-1:0] bit_cnt;
  logic [7:0] rx_byte;

  spi_flash_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .cs_ni, .sclk_i, .mosi_i,
    .cs_fall_o(cs_fall), .cs_rise_o(cs_rise),
    .sclk_rise_o(ck_rise), .sclk_fall_o(ck_fall), .mosi_o(di)
  );

  spi_flash_rx #(.CNT_W(CNT_W)) u_rx (
    .clk_i, .rst_ni,
    .start_i(cs_fall), .end_i(cs_rise), .rise_i(ck_rise), .mosi_i(di),
    .active_o(active), .bit_cnt_o(bit_cnt), .byte_o(rx_byte), .done_o(done)
  );

  spi_flash_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni,
    .start_i(cs_fall), .end_i(cs_rise), .fall_i(ck_fall), .active_i(active),
    .bit_cnt_i(bit_cnt), .byte_i(rx_byte), .done_i(done),
    .busy_i, .rd_data_i, .miso_o, .miso_oe_o, .req_o, .op_o, .addr_o,
    .wr_valid_o, .wr_data_o, .rd_addr_o
  );
endmodule

// File: tb/sim_sflash_cmd_front.sv
module sim_sflash_cmd_front;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 10;
  localparam int BUSY_LEN = 3000;
  localparam int WD_CYCLES = 150000;
  localparam int NVEC = 9;
  // {wren, opcode, addr, ndata, extra_bits, exp_req, exp_op}
  localparam logic [41:0] VEC [NVEC] = '{
    {1'b1, 8'hDB, 24'h012345, 3'd0, 3'd0, 1'b1, 2'd2},
    {1'b1, 8'hD8, 24'h010000, 3'd0, 3'd0, 1'b1, 2'd3},
    {1'b1, 8'h0A, 24'h0000F0, 3'd2, 3'd0, 1'b1, 2'd0},
    {1'b1, 8'h02, 24'h000010, 3'd1, 3'd0, 1'b1, 2'd1},
    {1'b0, 8'hDB, 24'h000100, 3'd0, 3'd0, 1'b0, 2'd0},
    {1'b1, 8'hDB, 24'h000200, 3'd0, 3'd3, 1'b0, 2'd0},
    {1'b1, 8'h0A, 24'h000300, 3'd0, 3'd0, 1'b0, 2'd0},
    {1'b1, 8'h02, 24'h000400, 3'd1, 3'd5, 1'b0, 2'd0},
    {1'b1, 8'hD8, 24'h000000, 3'd0, 3'd0, 1'b1, 2'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b0, sclk = 1'b0, mosi = 1'b0, busy = 1'b0;
  logic miso, miso_oe, req, wr_valid;
  logic [1:0] op;
  logic [23:0] addr, rd_addr;
  logic [7:0] wr_data, rd_data;

  int n_chk = 0, n_bad = 0;
  int req_cnt = 0, wr_cnt = 0, oe_hits = 0, left = 0;
  logic [1:0] last_op;
  logic [23:0] last_addr;
  logic [7:0] wr_log [0:3];
  logic [7:0] tx_buf [0:31];
  logic [7:0] rx_buf [0:31];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  assign rd_data = mem_f(rd_addr);

  sflash_cmd_front u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .busy_i(busy), .req_o(req), .op_o(op),
    .addr_o(addr), .wr_valid_o(wr_valid), .wr_data_o(wr_data),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  // array sequencer model and port monitors
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; left <= 0;
    end else begin
      if (req) begin
        req_cnt <= req_cnt + 1; last_op <= op; last_addr <= addr;
        busy <= 1'b1; left <= BUSY_LEN;
      end else if (left > 0) begin
        left <= left - 1;
        if (left == 1) busy <= 1'b0;
      end
      if (wr_valid) begin
        wr_log[wr_cnt % 4] <= wr_data;
        wr_cnt <= wr_cnt + 1;
      end
      if (miso_oe) oe_hits <= oe_hits + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input int nbits, input bit cpol);
    sclk = cpol;
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      mosi = tx_buf[i/8][7 - i%8];
      repeat (HALF) @(negedge clk);
      rx_buf[i/8][7 - i%8] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    if (!cpol) sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] opc, input bit cpol);
    tx_buf[0] = opc;
    xfer(8, cpol);
  endtask

  task automatic rdsr(input int nbytes, input bit cpol);
    tx_buf[0] = 8'h05;
    for (int k = 1; k <= nbytes; k++) tx_buf[k] = 8'h00;
    xfer(8 + 8*nbytes, cpol);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int base, nd, nb;
    logic [41:0] v;
    // select held low through reset
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 oe after reset", miso_oe, 0);
    chk("R1 req after reset", req, 0);
    chk("R1 wr_valid after reset", wr_valid, 0);
    for (int i = 0; i < 8; i++) begin
      mosi = OPC_BIT(i);
      repeat (HALF) @(negedge clk); sclk = 1'b1;
      repeat (HALF) @(negedge clk); sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (20) @(negedge clk);
    rdsr(1, 0);
    chk("R12 no command before fresh select", rx_buf[1], 8'h00);
    chk("R1 status after reset", rx_buf[1], 8'h00);

    // table walk
    for (int r = 0; r < NVEC; r++) begin
      v = VEC[r];
      cmd1(8'h04, r[0]);
      if (v[41]) cmd1(8'h06, r[0]);
      nd = int'(v[8:6]);
      tx_buf[0] = v[40:33];
      tx_buf[1] = v[32:25]; tx_buf[2] = v[24:17]; tx_buf[3] = v[16:9];
      for (int k = 0; k < 6; k++) tx_buf[4+k] = 8'h30 + 8'(k);
      base = req_cnt;
      xfer(32 + 8*nd + int'(v[5:3]), r[0]);
      chk($sformatf("R7 R8 row %0d request count", r), req_cnt - base, {31'd0, v[2]});
      if (v[2]) begin
        chk($sformatf("R7 row %0d op", r), last_op, v[1:0]);
        chk($sformatf("R7 row %0d addr", r), last_addr, v[32:9]);
      end
      wait_idle();
    end

    // status and latch, mode 3
    cmd1(8'h06, 1);
    rdsr(2, 1);
    chk("R3 R6 status after enable byte0", rx_buf[1], 8'h02);
    chk("R2 R3 status mode 3 byte1", rx_buf[2], 8'h02);
    cmd1(8'h04, 1);
    rdsr(1, 0);
    chk("R6 disable clears latch", rx_buf[1], 8'h00);
    tx_buf[0] = 8'h06; xfer(7, 0);
    rdsr(1, 0);
    chk("R6 short select rejects enable", rx_buf[1], 8'h00);
    tx_buf[0] = 8'h06; tx_buf[1] = 8'h00; xfer(16, 0);
    rdsr(1, 0);
    chk("R6 two-byte enable accepted", rx_buf[1], 8'h02);
    cmd1(8'h04, 0);

    // read, mode 0
    tx_buf[0] = 8'h03; tx_buf[1] = 8'h00; tx_buf[2] = 8'h12; tx_buf[3] = 8'hFE;
    base = oe_hits;
    xfer(32 + 24, 0);
    chk("R4 read byte0", rx_buf[4], mem_f(24'h0012FE));
    chk("R4 read byte1", rx_buf[5], mem_f(24'h0012FF));
    chk("R4 read byte2 crosses page", rx_buf[6], mem_f(24'h001300));
    chk("R4 output enabled", oe_hits > base, 1);
    chk("R12 oe low after deselect", miso_oe, 0);

    // fast read, mode 3
    tx_buf[0] = 8'h0B; tx_buf[1] = 8'h01; tx_buf[2] = 8'h02; tx_buf[3] = 8'h03; tx_buf[4] = 8'h00;
    xfer(40 + 16, 1);
    chk("R5 R2 fast read byte0", rx_buf[5], mem_f(24'h010203));
    chk("R5 fast read byte1", rx_buf[6], mem_f(24'h010204));

    // page write data stream and busy behaviour
    cmd1(8'h06, 0);
    tx_buf[0] = 8'h0A; tx_buf[1] = 8'h00; tx_buf[2] = 8'h05; tx_buf[3] = 8'h20;
    tx_buf[4] = 8'h11; tx_buf[5] = 8'h22; tx_buf[6] = 8'h33;
    base = wr_cnt; nb = req_cnt;
    xfer(56, 0);
    chk("R13 byte count", wr_cnt - base, 3);
    chk("R13 byte0", wr_log[base % 4], 8'h11);
    chk("R13 byte1", wr_log[(base+1) % 4], 8'h22);
    chk("R13 byte2", wr_log[(base+2) % 4], 8'h33);
    chk("R7 page write request", req_cnt - nb, 1);
    chk("R7 page write op", last_op, 2'd0);
    rdsr(1, 0);
    chk("R3 status while busy", rx_buf[1], 8'h03);
    tx_buf[0] = 8'h03; tx_buf[1] = 8'h00; tx_buf[2] = 8'h00; tx_buf[3] = 8'h00;
    base = oe_hits;
    xfer(40, 0);
    chk("R10 read ignored while busy", oe_hits - base, 0);
    cmd1(8'h06, 0);
    tx_buf[0] = 8'hDB; tx_buf[1] = 8'h00; tx_buf[2] = 8'h01; tx_buf[3] = 8'h00;
    nb = req_cnt;
    xfer(32, 0);
    chk("R10 erase ignored while busy", req_cnt - nb, 0);
    wait_idle();
    rdsr(1, 0);
    chk("R9 latch cleared at end of cycle", rx_buf[1], 8'h00);

    // status re-sampled during a long select
    cmd1(8'h06, 0);
    tx_buf[0] = 8'hD8; tx_buf[1] = 8'h00; tx_buf[2] = 8'h00; tx_buf[3] = 8'h00;
    xfer(32, 0);
    rdsr(24, 0);
    chk("R3 stream first byte busy", rx_buf[1], 8'h03);
    chk("R3 stream last byte idle", rx_buf[24], 8'h00);
    wait_idle();

    // deep power-down
    cmd1(8'hB9, 0);
    base = oe_hits;
    rdsr(1, 0);
    chk("R11 status ignored in power-down", oe_hits - base, 0);
    cmd1(8'h06, 0);
    cmd1(8'hAB, 0);
    base = oe_hits;
    rdsr(1, 0);
    chk("R11 enable was ignored", rx_buf[1], 8'h00);
    chk("R11 output back after release", oe_hits > base, 1);
    cmd1(8'h06, 0);
    rdsr(1, 0);
    chk("R11 R6 enable after release", rx_buf[1], 8'h02);

    summary();
    $finish;
  end

  function automatic logic OPC_BIT(input int i);
    logic [7:0] w = 8'h06;
    return w[7 - i];
  endfunction
endmodule